// File: doc/BRIEF.md
# Byte-Accessed Timer with Coherent 16-bit Snapshots

This block is a free-running up-counter with one capture register and a parameterised number of compare units. All of its values are reached through a narrow register port that moves one byte per access. Each wide value is split into a low byte and a high byte at two adjacent addresses. Address bit 0 selects the high byte.

Software reads a wide value low byte first. That access freezes the matching high byte in a hold register, and the high-byte read that follows returns the frozen byte. Software writes a compare value low byte first as well. The low byte waits in a staging register and does not reach the compare unit. The later high-byte write commits both bytes in a single clock. The counter keeps running through every access.

The count and the capture value each have their own read hold. Writes use a separate staging byte. Because of this, reads placed between the two halves of a compare write do not disturb the pending value. A rising edge on the capture input copies the counter into the capture register. Each compare unit raises its match output during every cycle in which the counter equals that unit's compare value.

Top module: `byte_timer`

## Requirements
- R1: After reset, the counter, the capture register, every compare register, both read holds and the write staging byte are zero, and read data is zero.
- R2: The counter advances by one on every clock and wraps from 0xFFFF to 0x0000. Register accesses never stall it.
- R3: A read at address 0 returns the counter's low byte as it stood on the clock edge that took the read. On that same edge the counter's high byte is copied into the count hold.
- R4: A read at address 1 returns the count hold, not the live high byte. Without a prior address-0 read, it returns the last value latched, which is zero after reset.
- R5: The capture register loads the counter value present on the first clock edge at which the capture input is sampled high after being sampled low. Holding the input high does not reload it.
- R6: Reads at address 2 (capture low, latching the capture high byte) and address 3 (returning that latched byte) use a hold separate from the count hold.
- R7: A write to a compare unit's low address (4 + 2k) changes only the staging byte. A read of that unit's compare value still returns the old value.
- R8: A write to a compare unit's high address (5 + 2k) loads that unit with {written byte, staging byte} in one clock. The staging byte is shared by all units, and reads do not alter it.
- R9: Match output k is high in exactly those cycles in which the counter equals compare value k. A newly committed value is compared from the first cycle after its commit.
- R10: Writes to addresses 0 to 3 have no effect on the counter or the capture register.
- R11: When a capture event and an address-2 read fall on the same edge, the read returns the pre-capture low byte and latches the pre-capture high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Register byte address |
| bus_wdata | input | BUS_W (8) | Write byte |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_rdata | output | BUS_W (8) | Read byte, valid the cycle after the strobe, held until the next read |
| capture_in | input | 1 | Capture trigger, sampled on the clock |
| match_o | output | NUM_CMP (2) | Per-unit compare match |

## Verification
Two pairs of functions can coincide in one cycle, and the bench provokes each pair deliberately.

The first pair is a capture event and a capture-low read. The bench raises the capture input on the same edge that takes an address-2 read. It expects the pre-capture byte on that read, and the new value only on a later read pair.

The second pair is a compare commit and a match. The bench commits a value equal to the counter one cycle ahead. Its own model of the counter and the compare registers then predicts the match output cycle by cycle. The same model covers the counter's wrap through zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // byte slots before the compare units; bit 0 of an address selects the high byte
  localparam int FIXED_SLOTS = 4;
  localparam int SLOT_CNT_LO = 0;
  localparam int SLOT_CNT_HI = 1;
  localparam int SLOT_CAP_LO = 2;
  localparam int SLOT_CAP_HI = 3;

  function automatic int cmp_lo_slot(input int unit);
    return FIXED_SLOTS + 2 * unit;
  endfunction

  function automatic int addr_width(input int units);
    return $clog2(FIXED_SLOTS + 2 * units);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap
);
  logic trig_d;
  logic fire;

  assign fire = trig && !trig_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d <= 1'b0;
      cap    <= '0;
    end else begin
      trig_d <= trig;
      if (fire) cap <= cnt;
    end
  end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cmp <= '0;
    else if (load) cmp <= load_val;
  end

  assign hit = (cnt == cmp);
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BUS_W-1:0]              wdata,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [2*BUS_W-1:0]            cnt,
  input  logic [2*BUS_W-1:0]            cap,
  input  logic [NUM_CMP-1:0][2*BUS_W-1:0] cmp,
  output logic [BUS_W-1:0]              rdata,
  output logic [NUM_CMP-1:0]            cmp_load,
  output logic [2*BUS_W-1:0]            cmp_value,
  output logic [BUS_W-1:0]              cnt_hold
);
  localparam int CNT_W = 2 * BUS_W;

  int                slot;
  logic [BUS_W-1:0]  cap_hold;
  logic [BUS_W-1:0]  wr_stage;
  logic [BUS_W-1:0]  rd_next;
  logic              stage_wr;

  assign slot      = int'(addr);
  assign cmp_value = {wdata, wr_stage};

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_load
    assign cmp_load[k] = wr && (slot == cmp_lo_slot(k) + 1);
  end

  always_comb begin
    stage_wr = 1'b0;
    for (int k = 0; k < NUM_CMP; k++)
      if (slot == cmp_lo_slot(k)) stage_wr = wr;
  end

  always_comb begin
    rd_next = '0;
    if      (slot == SLOT_CNT_LO) rd_next = cnt[BUS_W-1:0];
    else if (slot == SLOT_CNT_HI) rd_next = cnt_hold;
    else if (slot == SLOT_CAP_LO) rd_next = cap[BUS_W-1:0];
    else if (slot == SLOT_CAP_HI) rd_next = cap_hold;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (slot == cmp_lo_slot(k))     rd_next = cmp[k][BUS_W-1:0];
      if (slot == cmp_lo_slot(k) + 1) rd_next = cmp[k][CNT_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      cnt_hold <= '0;
      cap_hold <= '0;
      wr_stage <= '0;
    end else begin
      if (rd) begin
        rdata <= rd_next;
        if (slot == SLOT_CNT_LO) cnt_hold <= cnt[CNT_W-1:BUS_W];
        if (slot == SLOT_CAP_LO) cap_hold <= cap[CNT_W-1:BUS_W];
      end
      if (stage_wr) wr_stage <= wdata;
    end
  end
endmodule

// File: rtl/byte_timer.sv
module byte_timer #(
  parameter int BUS_W   = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = tmr_pkg::addr_width(NUM_CMP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               capture_in,
  output logic [NUM_CMP-1:0] match_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0]              cnt_q;
  logic [CNT_W-1:0]              cap_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0]            cmp_load;
  logic [CNT_W-1:0]              cmp_value;
  logic [BUS_W-1:0]              cnt_hold;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q)
  );

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .trig(capture_in), .cnt(cnt_q), .cap(cap_q)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    tmr_cmp_unit #(.CNT_W(CNT_W)) u_unit (
      .clk(clk), .rst_n(rst_n), .load(cmp_load[k]), .load_val(cmp_value),
      .cnt(cnt_q), .cmp(cmp_q[k]), .hit(match_o[k])
    );
  end

  tmr_regbank #(.BUS_W(BUS_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .cnt(cnt_q), .cap(cap_q), .cmp(cmp_q),
    .rdata(bus_rdata), .cmp_load(cmp_load), .cmp_value(cmp_value),
    .cnt_hold(cnt_hold)
  );
endmodule

// File: rtl/byte_timer_chk.sv
module byte_timer_chk #(
  parameter int BUS_W   = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [BUS_W-1:0]                bus_wdata,
  input logic                            bus_wr,
  input logic                            bus_rd,
  input logic                            capture_in,
  input logic [NUM_CMP-1:0]              match_o,
  input logic [2*BUS_W-1:0]              cnt,
  input logic [2*BUS_W-1:0]              cap,
  input logic [NUM_CMP-1:0][2*BUS_W-1:0] cmp,
  input logic [BUS_W-1:0]                cnt_hold
);
  localparam int CNT_W = 2 * BUS_W;

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + 1'b1);

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == 0) |=> cnt_hold == $past(cnt[CNT_W-1:BUS_W]));

  assert_capture_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_in && !$past(capture_in) && $past(rst_n)) |=> cap == $past(cnt));

  assert_lo_write_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == 4) |=> $stable(cmp[0]));

  assert_hi_write_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == 5) |=> cmp[0][CNT_W-1:BUS_W] == $past(bus_wdata));

  assert_match_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o[0] && !bus_wr) |=> !match_o[0]);
endmodule

bind byte_timer byte_timer_chk #(.BUS_W(BUS_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .capture_in(capture_in), .match_o(match_o),
  .cnt(cnt_q), .cap(cap_q), .cmp(cmp_q), .cnt_hold(cnt_hold)
);

// File: tb/test_byte_timer.sv
module test_byte_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_wr = 0, bus_rd = 0, capture_in = 0;
  logic [7:0] bus_rdata;
  logic [1:0] match_o;

  int checks = 0, failures = 0, cycles = 0;
  int seen0 = 0, seen1 = 0;

  // reference model, built from the requirements
  logic [15:0] m_cnt, m_cap, m_cmp0, m_cmp1;
  logic [7:0]  m_stage, h_cnt = 0, h_cap = 0;
  logic        m_prev;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  byte_timer i_byte_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .capture_in(capture_in), .match_o(match_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_cap <= 0; m_cmp0 <= 0; m_cmp1 <= 0; m_stage <= 0; m_prev <= 0;
    end else begin
      m_cnt  <= m_cnt + 16'd1;
      m_prev <= capture_in;
      if (capture_in && !m_prev) m_cap <= m_cnt;
      if (bus_wr) begin
        case (bus_addr)
          3'd4, 3'd6: m_stage <= bus_wdata;
          3'd5: m_cmp0 <= {bus_wdata, m_stage};
          3'd7: m_cmp1 <= {bus_wdata, m_stage};
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read, checks match every active cycle
  always @(posedge clk) begin
    #1;
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) chk(0, "scoreboard empty", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
    if (rst_n) begin
      logic [1:0] em;
      em = {m_cnt == m_cmp1, m_cnt == m_cmp0};
      if (em != 0 || match_o != 0) chk(match_o == em, "R9 match", match_o, em);
      if (em[0] && match_o[0]) seen0++;
      if (em[1] && match_o[1]) seen1++;
    end
  end

  task automatic rd(input logic [2:0] a, input string tag, input bit cap_now = 0);
    logic [7:0] e;
    @(negedge clk);
    case (a)
      3'd0: begin e = m_cnt[7:0]; h_cnt = m_cnt[15:8]; end
      3'd1: e = h_cnt;
      3'd2: begin e = m_cap[7:0]; h_cap = m_cap[15:8]; end
      3'd3: e = h_cap;
      3'd4: e = m_cmp0[7:0];
      3'd5: e = m_cmp0[15:8];
      3'd6: e = m_cmp1[7:0];
      default: e = m_cmp1[15:8];
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1;
    if (cap_now) capture_in = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(bus_rdata == 0, "R1 rdata reset", bus_rdata, 0);
    rst_n = 1;
    // R1 / R4: high read without low read returns zero hold
    rd(3'd1, "R4 cnt hi before any lo read");
    rd(3'd5, "R1 cmp0 hi reset");
    rd(3'd6, "R1 cmp1 lo reset");
    rd(3'd2, "R1 cap lo reset");
    rd(3'd3, "R1 cap hi reset");
    // R2 / R3 / R4: snapshot pairs with gaps
    for (int i = 0; i < 4; i++) begin
      rd(3'd0, "R3 cnt lo");
      repeat (i * 37) @(negedge clk);
      rd(3'd1, "R4 cnt hi held");
    end
    // R3/R4 boundary: low byte at 0xFF, high byte rolls before hi read
    while (m_cnt[7:0] != 8'hFE) @(negedge clk);
    rd(3'd0, "R3 cnt lo at FF");
    repeat (3) @(negedge clk);
    rd(3'd1, "R4 cnt hi frozen across carry");
    rd(3'd1, "R4 cnt hi repeat returns last latch");
    // R5: capture edge, level held
    @(negedge clk); capture_in = 1;
    repeat (20) @(negedge clk);
    rd(3'd2, "R5 cap lo");
    rd(3'd3, "R5 cap hi");
    capture_in = 0;
    // R6: holds are independent
    rd(3'd0, "R6 cnt lo");
    repeat (300) @(negedge clk);
    rd(3'd2, "R6 cap lo between");
    rd(3'd1, "R6 cnt hi unaffected by cap read");
    rd(3'd3, "R6 cap hi");
    // R11: capture event on the same edge as capture low read
    @(negedge clk);
    rd(3'd2, "R11 cap lo returns pre-capture", 1);
    rd(3'd3, "R11 cap hi pre-capture");
    capture_in = 0;
    rd(3'd2, "R11 cap lo new value");
    rd(3'd3, "R11 cap hi new value");
    // R7 / R8: staged write with reads in between
    wr(3'd4, 8'h34);
    rd(3'd4, "R7 cmp0 lo unchanged after lo write");
    rd(3'd0, "R8 interleaved cnt lo");
    rd(3'd1, "R8 interleaved cnt hi");
    wr(3'd5, 8'h92);
    rd(3'd4, "R8 cmp0 lo committed");
    rd(3'd5, "R8 cmp0 hi committed");
    // R8: staging shared across units
    wr(3'd6, 8'h5A);
    rd(3'd6, "R7 cmp1 lo unchanged");
    wr(3'd5, 8'h07);
    rd(3'd4, "R8 cmp0 lo from shared stage");
    rd(3'd7, "R8 cmp1 hi untouched");
    // R9: commit a value the counter reaches in the first cycle after commit
    begin
      logic [15:0] t;
      @(negedge clk);
      t = m_cnt + 16'd2;
      bus_addr = 3'd6; bus_wdata = t[7:0]; bus_wr = 1;
      @(negedge clk);
      bus_addr = 3'd7; bus_wdata = t[15:8];
      @(negedge clk);
      bus_wr = 0;
    end
    repeat (4) @(negedge clk);
    chk(seen1 > 0, "R9 cmp1 immediate match seen", seen1, 1);
    // R10: writes to count/capture addresses ignored
    for (int a = 0; a < 4; a++) wr(3'(a), 8'hAA);
    rd(3'd0, "R10 cnt lo after ignored writes");
    rd(3'd1, "R10 cnt hi after ignored writes");
    rd(3'd2, "R10 cap lo after ignored writes");
    rd(3'd3, "R10 cap hi after ignored writes");
    // R2 / R9: wrap with compares at both ends of the range
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    seen0 = 0; seen1 = 0;
    while (m_cnt != 16'h0008) @(negedge clk);
    chk(seen0 == 1, "R9 match at 0x0000 after wrap", seen0, 1);
    chk(seen1 == 1, "R9 match at 0xFFFF", seen1, 1);
    rd(3'd0, "R2 cnt lo after wrap");
    rd(3'd1, "R2 cnt hi after wrap");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule